// File: doc/BRIEF.md
# User-Defined Glyph Store

This block holds sixteen custom 5x7 dot-matrix symbols for a character display. A host defines a symbol in two steps. First it writes a glyph number into a glyph register. Then it writes the symbol's seven rows one at a time. Each row write carries a row number and a five-dot pattern, and the block stores that pattern into the glyph that the register currently names.

The display-scan logic reads from a separate port. It presents a glyph index and a row index and gets the five-dot pattern back in the same cycle, with no clock edge in between. Bit 4 of a stored pattern is the leftmost column and bit 0 is the rightmost. The row value 7 names no row. Writes to it are dropped, and reads from it return blank. Reset clears every glyph to blank and sets the glyph register to 0.

Top module: `glyph_store`

## Requirements
- R1: While reset is held, and after it is released, every row of every glyph reads as 0. The glyph register holds 0, so a row write made before any register load lands in glyph 0.
- R2: A register load (`wr_en`=1, `wr_sel`=0) takes `wr_data[3:0]` as the glyph number and ignores `wr_data[7:4]`.
- R3: A row write (`wr_en`=1, `wr_sel`=1, `wr_row` between 0 and 6) stores `wr_data[4:0]` into that row of the glyph in the register. The new pattern is visible on `rd_dots` right after that rising edge.
- R4: Bits `wr_data[7:5]` of a row write are not stored.
- R5: Bit 4 of a row pattern is the leftmost column and bit 0 is the rightmost. The bit positions are kept unchanged from `wr_data` to `rd_dots`.
- R6: A row write with `wr_row`=7 changes nothing, and a read with `rd_row`=7 returns 0.
- R7: With `wr_en`=0, neither the glyph register nor any stored row changes, whatever the other write inputs are.
- R8: A row write leaves the glyph register unchanged, and a register load leaves every stored row unchanged.
- R9: A row write changes only the addressed row of the addressed glyph. Every other row and glyph keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_sel | input | 1 | 0 = load the glyph register, 1 = write a row |
| wr_row | input | 3 | Row number for a row write (0 to 6 valid) |
| wr_data | input | 8 | Glyph number (bits 3:0) or row pattern (bits 4:0) |
| rd_glyph | input | 4 | Glyph index for the scan read |
| rd_row | input | 3 | Row index for the scan read |
| rd_dots | output | 5 | Row pattern; bit 4 is the leftmost column |

## Verification
The scan read is combinational, so `rd_dots` follows `rd_glyph` and `rd_row` within the same cycle. A write shows up only after the rising edge that takes it. The bench therefore drives each write at a falling edge, removes it at the next falling edge, sets the read indices there and samples shortly afterwards. That sample point is one edge after the write. A reset assertion clears the storage at once. Release goes through two synchronizing flops, so the bench waits three edges before the next write.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_ROW  = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/glyph_rst_sync.sv
module glyph_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/glyph_addr_reg.sv
module glyph_addr_reg
  import glyph_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_int_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  glyph_idx
);
  logic             load_en;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    load_en = wr_en && (wr_sel == SEL_ADDR);
    idx_d   = idx_q;
    if (load_en) idx_d = wr_data[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) idx_q <= '0;
    else            idx_q <= idx_d;
  end

  assign glyph_idx = idx_q;
endmodule

// File: rtl/glyph_row_mem.sv
module glyph_row_mem
  import glyph_pkg::*;
#(
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int ROW_W  = 3
) (
  input  logic              clk,
  input  logic              rst_int_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  wr_glyph,
  input  logic [IDX_W-1:0]  rd_glyph,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [COLS-1:0]   rd_dots
);
  localparam int CELLS  = GLYPHS * ROWS;
  localparam int CELL_W = $clog2(CELLS);

  logic                   row_wr_en;
  logic [COLS-1:0]        wr_dots;
  logic [CELLS*COLS-1:0]  cells_flat;

  always_comb begin
    row_wr_en = wr_en && (wr_sel == SEL_ROW);
    wr_dots   = wr_data[COLS-1:0];
  end

  for (genvar g = 0; g < GLYPHS; g++) begin : g_glyph
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic            hit;
      logic [COLS-1:0] row_d;
      logic [COLS-1:0] row_q;

      always_comb begin
        hit   = row_wr_en && (wr_glyph == IDX_W'(g)) && (wr_row == ROW_W'(r));
        row_d = row_q;
        if (hit) row_d = wr_dots;
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) row_q <= '0;
        else            row_q <= row_d;
      end

      assign cells_flat[(g*ROWS+r)*COLS +: COLS] = row_q;
    end
  end

  logic [CELL_W-1:0] cell_sel;
  logic              rd_valid;

  always_comb begin
    rd_valid = (32'(rd_glyph) < GLYPHS) && (32'(rd_row) < ROWS);
    cell_sel = CELL_W'(rd_glyph) * CELL_W'(ROWS) + CELL_W'(rd_row);
    rd_dots  = '0;
    if (rd_valid) rd_dots = cells_flat[32'(cell_sel)*COLS +: COLS];
  end
endmodule

// File: rtl/glyph_store.sv
module glyph_store #(
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(GLYPHS),
  parameter int ROW_W  = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_glyph,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [COLS-1:0]   rd_dots
);
  logic             rst_int_n;
  logic [IDX_W-1:0] glyph_idx;

  glyph_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  glyph_addr_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_addr_reg (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .glyph_idx (glyph_idx)
  );

  glyph_row_mem #(
    .GLYPHS (GLYPHS),
    .ROWS   (ROWS),
    .COLS   (COLS),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .ROW_W  (ROW_W)
  ) u_row_mem (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_row    (wr_row),
    .wr_data   (wr_data),
    .wr_glyph  (glyph_idx),
    .rd_glyph  (rd_glyph),
    .rd_row    (rd_row),
    .rd_dots   (rd_dots)
  );
endmodule

// File: rtl/glyph_store_chk.sv
module glyph_store_chk #(
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int ROW_W  = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [ROW_W-1:0]  wr_row,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  glyph_idx,
  input logic [IDX_W-1:0]  rd_glyph,
  input logic [ROW_W-1:0]  rd_row,
  input logic [COLS-1:0]   rd_dots
);
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !wr_sel) |=> (glyph_idx == $past(wr_data[IDX_W-1:0]))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en && !wr_sel) |=> $stable(glyph_idx)); // R8

  AST_ROW_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_sel && (32'(wr_row) < ROWS)) |=>
      (!((rd_glyph == $past(glyph_idx)) && (rd_row == $past(wr_row)))
       || (rd_dots == $past(wr_data[COLS-1:0])))); // R3

  AST_ROW7_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (32'(rd_row) >= ROWS) |-> (rd_dots == '0)); // R6

  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$past(wr_en) && $stable(rd_glyph) && $stable(rd_row)) |-> $stable(rd_dots)); // R7
endmodule

bind glyph_store glyph_store_chk #(
  .ROWS   (ROWS),
  .COLS   (COLS),
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W),
  .ROW_W  (ROW_W)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_row    (wr_row),
  .wr_data   (wr_data),
  .glyph_idx (glyph_idx),
  .rd_glyph  (rd_glyph),
  .rd_row    (rd_row),
  .rd_dots   (rd_dots)
);

// File: tb/glyph_store_bench.sv
module glyph_store_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       wr_sel;
  logic [2:0] wr_row;
  logic [7:0] wr_data;
  logic [3:0] rd_glyph;
  logic [2:0] rd_row;
  logic [4:0] rd_dots;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  glyph_store u_glyph_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_row   (wr_row),
    .wr_data  (wr_data),
    .rd_glyph (rd_glyph),
    .rd_row   (rd_row),
    .rd_dots  (rd_dots)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {req[3:0], op[1:0], row[2:0], data[7:0], rd_glyph[3:0], rd_row[2:0], exp[4:0]}
  // op: 0 = no write, 1 = glyph register load, 2 = row write
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd1, 2'd2, 3'd0, 8'h1F, 4'd0,  3'd0, 5'h1F}, // R1 register is 0 after reset
    {4'd2, 2'd1, 3'd0, 8'hF5, 4'd5,  3'd0, 5'h00}, // R2 upper nibble dropped
    {4'd3, 2'd2, 3'd0, 8'h1F, 4'd5,  3'd0, 5'h1F}, // R3 top bar in glyph 5
    {4'd4, 2'd2, 3'd1, 8'hF0, 4'd5,  3'd1, 5'h10}, // R4 D7-D5 dropped
    {4'd5, 2'd2, 3'd3, 8'h1D, 4'd5,  3'd3, 5'h1D}, // R5 column bits kept in place
    {4'd9, 2'd0, 3'd0, 8'h00, 4'd0,  3'd0, 5'h1F}, // R9 glyph 0 untouched
    {4'd6, 2'd2, 3'd7, 8'h1F, 4'd5,  3'd7, 5'h00}, // R6 row 7 dropped
    {4'd8, 2'd1, 3'd0, 8'h0A, 4'd5,  3'd1, 5'h10}, // R8 load leaves rows alone
    {4'd3, 2'd2, 3'd6, 8'h15, 4'd10, 3'd6, 5'h15}, // R3 write into glyph 10
    {4'd9, 2'd0, 3'd0, 8'h00, 4'd5,  3'd6, 5'h00}  // R9 glyph 5 row 6 untouched
  };

  task automatic check(input int req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rd_dots actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input bit sel, input logic [2:0] row, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_row = row; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_chk(input int req, input logic [3:0] g, input logic [2:0] r, input logic [4:0] exp);
    rd_glyph = g; rd_row = r;
    #1;
    check(req, rd_dots, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_row = '0; wr_data = '0;
    rd_glyph = '0; rd_row = '0;
    repeat (3) @(negedge clk);
    read_chk(1, 4'd3, 3'd2, 5'h00); // R1 blank while in reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk(1, 4'd15, 3'd6, 5'h00); // R1 blank after release

    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] v;
      v = VEC[i];
      @(negedge clk);
      if (v[24:23] != 2'd0) begin
        wr_en = 1'b1; wr_sel = (v[24:23] == 2'd2); wr_row = v[22:20]; wr_data = v[19:12];
      end
      @(negedge clk);
      wr_en = 1'b0;
      read_chk(int'(v[28:25]), v[11:8], v[7:5], v[4:0]);
    end

    // R7: strobe low, other write inputs busy; glyph 10 row 6 must hold
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b1; wr_row = 3'd6; wr_data = 8'h0E;
    @(negedge clk);
    wr_sel = 1'b0; wr_data = 8'h03;
    @(negedge clk);
    read_chk(7, 4'd10, 3'd6, 5'h15);
    // R7: the unstrobed register load must not have moved the register from 10
    do_write(1'b1, 3'd2, 8'h07);
    read_chk(7, 4'd10, 3'd2, 5'h07);
    read_chk(7, 4'd3, 3'd2, 5'h00);

    // R1: reset mid-run clears contents and the register
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, rd_dots, 5'h00); // glyph 3 row 2 still selected
    read_chk(1, 4'd10, 3'd6, 5'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_write(1'b1, 3'd4, 8'h01);
    read_chk(1, 4'd0, 3'd4, 5'h01);
    read_chk(9, 4'd10, 3'd4, 5'h00);
    read_chk(6, 4'd0, 3'd7, 5'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule